// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the fetch side of a transmit DMA engine. Software keeps a ring of two-word descriptors in memory. Each descriptor holds a buffer byte address and a control word. Software publishes new work by moving a produce index forward. The engine keeps its own consume index. While the two indices differ and the engine is enabled, it reads the descriptor at the consume index. It then reads the buffer one aligned word at a time and sends the fragment out as a byte stream with a valid/ready handshake. It writes one status word for the descriptor and then moves the consume index on, wrapping it after the programmed count minus one.

A frame can be built from several descriptors, one per gather fragment. Only the final descriptor of a frame carries the last flag. The last marker on the byte stream rises only on the final byte of such a descriptor. The engine does not act on the CRC, padding, oversize and override request bits. It presents them beside the stream as sideband outputs, so that a later MAC stage can act on them.

Two event pulses tell software about progress. The first marks a completed descriptor that asked for an interrupt. The second marks the moment the consume index catches up with the produce index. A fragment that leaves its frame open when the ring runs dry is reported as an underrun in its status word.

Top module: `txring_dma`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cons_idx is 0, and mem_req, tx_valid, evt_done and evt_finished are 0.
- R2: Descriptor i sits at cfg_desc_base + 8*i. Word 0 is the buffer byte address and word 1 is the control word. The fragment length is control bits 10:0 plus one. The bytes are sent in rising address order. The byte at address a is lane a[1:0] of the word at address a with bits 1:0 cleared, where lane 0 is bits 7:0. tx_data and tx_last hold steady while tx_valid is high and tx_ready is low.
- R3: tx_last is high only on the final byte of a descriptor whose control bit 30 (last fragment) is set.
- R4: A status word is written to cfg_stat_base + 4*i with mem_we high. Its value is 0 for a normal completion. cons_idx changes only after the write of that status word is acknowledged, or on ring_clr.
- R5: When a descriptor without bit 30 is written back while the next index equals prod_idx, its status is 0xE0000000. This means bit 31 (error), bit 30 (no descriptor) and bit 29 (underrun) are set.
- R6: cons_idx advances by one per descriptor and goes from cfg_count_m1 to 0.
- R7: evt_done is a one-cycle pulse in the cycle after the status write of a descriptor whose control bit 31 is set. At all other times it is low.
- R8: evt_finished is a one-cycle pulse in the cycle after a status write that leaves cons_idx equal to prod_idx. At all other times it is low.
- R9: While enable is low, no new descriptor is fetched: no byte goes out and cons_idx stays the same.
- R10: ring_clr high at a clock edge sets cons_idx to 0 for the next cycle.
- R11: While a byte is sent, tx_crc, tx_pad, tx_huge and tx_override equal control bits 29, 28, 27 and 26 of its descriptor.
- R12: Once mem_req is raised, it stays high, and mem_addr and mem_we hold steady, until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new descriptor fetches |
| ring_clr | input | 1 | Clears the consume index and aborts any descriptor in progress |
| cfg_desc_base | input | ADDR_W | Byte address of descriptor 0 |
| cfg_stat_base | input | ADDR_W | Byte address of status word 0 |
| cfg_count_m1 | input | IDX_W | Ring length minus one |
| prod_idx | input | IDX_W | Software produce index |
| cons_idx | output | IDX_W | Engine consume index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (status), else read |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Status write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes at this edge |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_crc | output | 1 | CRC append request of current fragment |
| tx_pad | output | 1 | Short-frame pad request of current fragment |
| tx_huge | output | 1 | Oversize frame allowed for current fragment |
| tx_override | output | 1 | Per-frame override of current fragment |
| evt_done | output | 1 | Descriptor with interrupt request completed |
| evt_finished | output | 1 | Ring drained up to the produce index |

## Verification
The hardest case to reach from the ports is the underrun. It needs a fragment without the last flag to reach write-back at a moment when the produce index matches the next slot. The stimulus publishes a lone open fragment and lets it drain. The other hard cases are the wrap of the consume index at a ring length that is not a power of two, and a clear of the index while it is away from zero. The stimulus runs enough descriptors to wrap a six-entry ring several times, with odd buffer start addresses. It then parks the engine with enable low, rewinds the produce index to zero and pulses the clear. Memory and sink stalls come from a pseudo-random pattern, so that the request-hold and byte-hold rules are tested under backpressure.

// File: rtl/txr_pkg.sv
// Package txr_pkg: shared encodings of the transmit ring fetcher.
// Holds the engine state type, control/status bit positions and the
// decoded fragment flag record. Assumes 32-bit descriptor and status words.
package txr_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ADDR,
        S_RD_CTRL,
        S_STREAM,
        S_WR_STAT
    } fetch_state_t;

    localparam int CB_INT  = 31;
    localparam int CB_LAST = 30;
    localparam int CB_CRC  = 29;
    localparam int CB_PAD  = 28;
    localparam int CB_HUGE = 27;
    localparam int CB_OVR  = 26;

    localparam int SB_ERR    = 31;
    localparam int SB_NODESC = 30;
    localparam int SB_UNDER  = 29;

    typedef struct packed {
        logic intr;
        logic last;
        logic crc;
        logic pad;
        logic huge;
        logic ovr;
    } frag_flags_t;

endpackage

// File: rtl/txr_ring_idx.sv
// Module txr_ring_idx: ring index arithmetic.
// Gives the successor of the consume index, wrapping after the programmed
// count minus one, and the two emptiness compares against the produce index.
// Assumes the produce index never exceeds the count minus one.
module txr_ring_idx #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] cons,
    input  logic [IDX_W-1:0] prod,
    input  logic [IDX_W-1:0] count_m1,
    output logic [IDX_W-1:0] next,
    output logic             empty,
    output logic             next_empty
);

    // Successor index with wrap at the programmed ring end.
    always_comb begin
        next = (cons == count_m1) ? '0 : cons + IDX_W'(1);
    end

    assign empty      = (cons == prod);
    assign next_empty = (next == prod);

endmodule

// File: rtl/txr_byte_pick.sv
// Module txr_byte_pick: selects one byte lane of a fetched word.
// Lane 0 is the least significant byte (little-endian byte order).
// Assumes WORD_W is a multiple of 8.
module txr_byte_pick #(
    parameter int WORD_W = 32,
    parameter int LANE_W = $clog2(WORD_W / 8)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_o
);

    localparam int LANES = WORD_W / 8;

    logic [7:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[8*g +: 8];
    end

    assign byte_o = lane_bytes[lane];

endmodule

// File: rtl/txring_dma.sv
// Module txring_dma: transmit descriptor ring fetcher.
// Walks descriptors from the consume index up to the produce index. It
// reads the buffer address and control words, sends the fragment bytes
// with a last marker, writes one status word and then advances the
// consume index. Assumes a single-beat memory port that holds read data
// valid with mem_ack, and word-aligned descriptor and status bases.
module txring_dma
    import txr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ring_clr,
    input  logic [ADDR_W-1:0] cfg_desc_base,
    input  logic [ADDR_W-1:0] cfg_stat_base,
    input  logic [IDX_W-1:0]  cfg_count_m1,
    input  logic [IDX_W-1:0]  prod_idx,
    output logic [IDX_W-1:0]  cons_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              tx_crc,
    output logic              tx_pad,
    output logic              tx_huge,
    output logic              tx_override,
    output logic              evt_done,
    output logic              evt_finished
);

    localparam int LANE_W = $clog2(WORD_W / 8);

    fetch_state_t      state_q;
    logic [IDX_W-1:0]  cons_q;
    logic [ADDR_W-1:0] cur_q;
    logic [LEN_W-1:0]  remain_q;
    frag_flags_t       flags_q;
    logic [WORD_W-1:0] word_q;
    logic              word_vld_q;
    logic              done_q;
    logic              fin_q;

    logic [IDX_W-1:0]  next_idx;
    logic              ring_empty;
    logic              next_empty;
    logic [ADDR_W-1:0] desc_addr;
    logic [ADDR_W-1:0] stat_addr;
    logic [31:0]       status_w;
    logic              byte_fire;
    logic              frag_end;

    txr_ring_idx #(.IDX_W(IDX_W)) u_idx (
        .cons       (cons_q),
        .prod       (prod_idx),
        .count_m1   (cfg_count_m1),
        .next       (next_idx),
        .empty      (ring_empty),
        .next_empty (next_empty)
    );

    txr_byte_pick #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_pick (
        .word   (word_q),
        .lane   (cur_q[LANE_W-1:0]),
        .byte_o (tx_data)
    );

    // Descriptor and status slot addresses for the current consume index.
    assign desc_addr = cfg_desc_base + (ADDR_W'(cons_q) << 3);
    assign stat_addr = cfg_stat_base + (ADDR_W'(cons_q) << 2);

    // Status value: underrun report when an open frame meets an empty ring.
    always_comb begin
        status_w = '0;
        if (!flags_q.last && next_empty) begin
            status_w[SB_ERR]    = 1'b1;
            status_w[SB_NODESC] = 1'b1;
            status_w[SB_UNDER]  = 1'b1;
        end
    end

    // Memory request decode per engine state.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = desc_addr;
        unique case (state_q)
            S_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
            end
            S_RD_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(4);
            end
            S_STREAM: begin
                mem_req  = !word_vld_q;
                mem_addr = {cur_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            end
            S_WR_STAT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = stat_addr;
            end
            default: mem_req = 1'b0;
        endcase
    end

    assign mem_wdata = status_w;
    assign tx_valid  = (state_q == S_STREAM) && word_vld_q;
    assign frag_end  = (remain_q == '0);
    assign tx_last   = flags_q.last && frag_end;
    assign byte_fire = tx_valid && tx_ready;

    // Engine sequencing: fetch, stream, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cons_q     <= '0;
            cur_q      <= '0;
            remain_q   <= '0;
            flags_q    <= '0;
            word_q     <= '0;
            word_vld_q <= 1'b0;
        end else if (ring_clr) begin
            state_q    <= S_IDLE;
            cons_q     <= '0;
            word_vld_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (enable && !ring_empty) state_q <= S_RD_ADDR;
                end
                S_RD_ADDR: begin
                    if (mem_ack) begin
                        cur_q   <= mem_rdata[ADDR_W-1:0];
                        state_q <= S_RD_CTRL;
                    end
                end
                S_RD_CTRL: begin
                    if (mem_ack) begin
                        remain_q   <= mem_rdata[LEN_W-1:0];
                        flags_q    <= '{intr: mem_rdata[CB_INT],  last: mem_rdata[CB_LAST],
                                        crc:  mem_rdata[CB_CRC],  pad:  mem_rdata[CB_PAD],
                                        huge: mem_rdata[CB_HUGE], ovr:  mem_rdata[CB_OVR]};
                        word_vld_q <= 1'b0;
                        state_q    <= S_STREAM;
                    end
                end
                S_STREAM: begin
                    if (!word_vld_q) begin
                        if (mem_ack) begin
                            word_q     <= mem_rdata;
                            word_vld_q <= 1'b1;
                        end
                    end else if (byte_fire) begin
                        cur_q    <= cur_q + ADDR_W'(1);
                        remain_q <= remain_q - LEN_W'(1);
                        if (frag_end) begin
                            word_vld_q <= 1'b0;
                            state_q    <= S_WR_STAT;
                        end else if (&cur_q[LANE_W-1:0]) begin
                            word_vld_q <= 1'b0;
                        end
                    end
                end
                S_WR_STAT: begin
                    if (mem_ack) begin
                        cons_q  <= next_idx;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Event pulses raised for one cycle after each status write-back.
    always_ff @(posedge clk) begin
        if (!rst_n || ring_clr) begin
            done_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            done_q <= (state_q == S_WR_STAT) && mem_ack && flags_q.intr;
            fin_q  <= (state_q == S_WR_STAT) && mem_ack && next_empty;
        end
    end

    assign cons_idx     = cons_q;
    assign evt_done     = done_q;
    assign evt_finished = fin_q;
    assign tx_crc       = flags_q.crc;
    assign tx_pad       = flags_q.pad;
    assign tx_huge      = flags_q.huge;
    assign tx_override  = flags_q.ovr;

endmodule

// File: rtl/txring_dma_chk.sv
// Module txring_dma_chk: temporal properties of the ring fetcher ports.
// Bound to every txring_dma instance. Assumes synchronous active-low reset.
module txring_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_clr,
    input logic [IDX_W-1:0]  prod_idx,
    input logic [IDX_W-1:0]  cons_idx,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              evt_done,
    input logic              evt_finished
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !ring_clr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !ring_clr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R2

    AST_CONS_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cons_idx) |-> ($past(ring_clr) || $past(mem_req && mem_ack && mem_we))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done); // R7

    AST_FIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_finished && !$past(ring_clr)) |-> (cons_idx == $past(prod_idx))); // R8

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ring_clr) |-> (cons_idx == '0)); // R10

endmodule

bind txring_dma txring_dma_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/txring_dma_test.sv
// Bench txring_dma_test: behavioural memory, throttled byte sink and a
// per-clock reference model built from queues and integers.
module txring_dma_test;

    localparam int          IDX_W     = 3;
    localparam int          CNT_M1    = 5;
    localparam logic [31:0] DESC_BASE = 32'h0000_0000;
    localparam logic [31:0] STAT_BASE = 32'h0000_0100;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enable;
    logic             ring_clr;
    logic [IDX_W-1:0] prod_idx;
    logic [IDX_W-1:0] cons_idx;
    logic             mem_req, mem_we, mem_ack;
    logic [31:0]      mem_addr, mem_wdata, mem_rdata;
    logic             tx_valid, tx_last, tx_ready;
    logic [7:0]       tx_data;
    logic             tx_crc, tx_pad, tx_huge, tx_override;
    logic             evt_done, evt_finished;
    logic             mem_go;
    logic             full_speed;

    logic [31:0] mem [0:255];

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int m_cons     = 0;
    bit m_exp_done = 0;
    bit m_exp_fin  = 0;
    int bytes_seen = 0;
    int wraps      = 0;
    int underruns  = 0;
    bit mon_on     = 0;
    int sw_prod    = 0;
    int bufptr     = 32'h201;
    int seed       = 7;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_ack   = mem_req & mem_go;

    txring_dma #(.ADDR_W(32), .IDX_W(IDX_W), .LEN_W(11)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ring_clr(ring_clr),
        .cfg_desc_base(DESC_BASE), .cfg_stat_base(STAT_BASE),
        .cfg_count_m1(IDX_W'(CNT_M1)), .prod_idx(prod_idx), .cons_idx(cons_idx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_crc(tx_crc), .tx_pad(tx_pad),
        .tx_huge(tx_huge), .tx_override(tx_override),
        .evt_done(evt_done), .evt_finished(evt_finished)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nxt(input int i);
        return (i == CNT_M1) ? 0 : i + 1;
    endfunction

    // Reference model compared on every falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            int ctrl;
            int n;
            int es;
            chk(int'(cons_idx) == m_cons, "R4 R6", "cons_idx", int'(cons_idx), m_cons);
            chk(evt_done == m_exp_done, "R7", "evt_done", int'(evt_done), int'(m_exp_done));
            chk(evt_finished == m_exp_fin, "R8", "evt_finished", int'(evt_finished), int'(m_exp_fin));
            m_exp_done = 0;
            m_exp_fin  = 0;
            if (tx_valid && tx_ready) begin
                bytes_seen++;
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected byte", int'(tx_data), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(tx_data) == (e & 255), "R2", "byte", int'(tx_data), e & 255);
                    chk(int'(tx_last) == ((e >> 8) & 1), "R3", "last", int'(tx_last), (e >> 8) & 1);
                    chk(int'({tx_crc, tx_pad, tx_huge, tx_override}) == ((e >> 9) & 15),
                        "R11", "sideband", int'({tx_crc, tx_pad, tx_huge, tx_override}), (e >> 9) & 15);
                end
            end
            if (mem_req && mem_ack && mem_we) begin
                ctrl = int'(mem[8'((int'(DESC_BASE) + 8 * m_cons + 4) >> 2)]);
                n    = nxt(m_cons);
                es   = (((ctrl >> 30) & 1) == 0 && n == int'(prod_idx)) ? 32'hE000_0000 : 0;
                if (es != 0) underruns++;
                chk(mem_addr == 32'(int'(STAT_BASE) + 4 * m_cons), "R4", "status address",
                    int'(mem_addr), int'(STAT_BASE) + 4 * m_cons);
                chk(int'(mem_wdata) == es, (es != 0) ? "R5" : "R4", "status value",
                    int'(mem_wdata), es);
                mem[mem_addr[9:2]] = mem_wdata;
                m_exp_done = ((ctrl >> 31) & 1) != 0;
                m_exp_fin  = (n == int'(prod_idx));
                if (n == 0) wraps++;
                m_cons = n;
            end
            if (ring_clr) m_cons = 0;
        end
    end

    // Pseudo-random memory and sink throttling.
    initial begin
        logic [7:0] lfsr;
        lfsr   = 8'h5A;
        mem_go = 1'b1;
        tx_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_go   = full_speed | lfsr[0] | lfsr[3];
            tx_ready = full_speed | lfsr[1] | lfsr[6];
        end
    end

    task automatic enq(input int len, input bit last, input bit intr, input bit [3:0] side);
        int di;
        int a;
        di = sw_prod;
        a  = bufptr;
        if (a + len > 32'h3F0) a = 32'h201;
        mem[8'((int'(DESC_BASE) + 8 * di) >> 2)]     = 32'(a);
        mem[8'((int'(DESC_BASE) + 8 * di + 4) >> 2)] = {intr, last, side, 15'b0, 11'(len - 1)};
        for (int i = 0; i < len; i++) begin
            logic [31:0] w;
            logic [7:0]  b;
            int          ad;
            b  = 8'(seed);
            seed = seed * 5 + 3;
            ad = a + i;
            w  = mem[8'(ad >> 2)];
            w[8 * (ad % 4) +: 8] = b;
            mem[8'(ad >> 2)] = w;
            exp_q.push_back(int'(b) | ((last && i == len - 1) ? 256 : 0) | (int'(side) << 9));
        end
        bufptr  = a + len + 3;
        sw_prod = nxt(di);
    endtask

    task automatic publish();
        prod_idx = IDX_W'(sw_prod);
    endtask

    task automatic drain();
        int t;
        t = 0;
        while ((m_cons != sw_prod || exp_q.size() != 0) && t < 5000) begin
            @(posedge clk);
            t++;
        end
        repeat (4) @(posedge clk);
        #1;
        chk(t < 5000, "R2", "ring drained", t, 0);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", m_cons, sw_prod);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int before_bytes;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        full_speed = 1'b0;
        rst_n    = 1'b0;
        enable   = 1'b1;
        ring_clr = 1'b0;
        prod_idx = '0;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(cons_idx == '0, "R1", "reset cons_idx", int'(cons_idx), 0);
        chk(!mem_req && !tx_valid, "R1", "reset req/valid", int'({mem_req, tx_valid}), 0);
        chk(!evt_done && !evt_finished, "R1", "reset events", int'({evt_done, evt_finished}), 0);
        mon_on = 1;
        @(posedge clk);
        #1;

        // Minimum length single-fragment frame.
        enq(1, 1, 1, 4'b1000);
        publish();
        drain();

        // Three-fragment frame, interrupt only on the final fragment.
        enq(5, 0, 0, 4'b1100);
        enq(7, 0, 0, 4'b1100);
        enq(4, 1, 1, 4'b1100);
        publish();
        drain();

        // Varied lengths, alignments and flags; wraps the ring several times.
        for (int k = 0; k < 14; k++) begin
            int frags;
            frags = 1 + (k % 3);
            for (int f = 0; f < frags; f++)
                enq(1 + ((k * 7 + f * 3) % 16), f == frags - 1, (k + f) % 2 == 1, 4'(k + f));
            publish();
            if (k % 2 == 1) drain();
        end
        drain();

        // Back-to-back traffic at full speed.
        full_speed = 1'b1;
        enq(9, 1, 1, 4'b0101);
        enq(2, 0, 0, 4'b0011);
        enq(3, 1, 0, 4'b0011);
        publish();
        drain();
        full_speed = 1'b0;

        // Open fragment followed by an empty ring.
        begin
            int ui;
            int u0;
            ui = sw_prod;
            u0 = underruns;
            enq(6, 0, 1, 4'b0010);
            publish();
            drain();
            chk(mem[8'((int'(STAT_BASE) + 4 * ui) >> 2)] == 32'hE000_0000, "R5",
                "underrun status in memory", int'(mem[8'((int'(STAT_BASE) + 4 * ui) >> 2)]), 32'hE000_0000);
            chk(underruns == u0 + 1, "R5", "underrun count", underruns, u0 + 1);
        end

        // Fetch gating by enable.
        enable = 1'b0;
        before_bytes = bytes_seen;
        begin
            int c0;
            c0 = int'(cons_idx);
            enq(4, 1, 0, 4'b0000);
            publish();
            repeat (40) @(posedge clk);
            #1;
            chk(bytes_seen == before_bytes, "R9", "bytes while disabled", bytes_seen, before_bytes);
            chk(int'(cons_idx) == c0, "R9", "cons while disabled", int'(cons_idx), c0);
        end
        enable = 1'b1;
        drain();
        if (sw_prod == 0) begin
            enq(3, 1, 0, 4'b0001);
            publish();
            drain();
        end

        // Index clear with the engine parked away from slot zero.
        enable = 1'b0;
        chk(sw_prod != 0, "R10", "parked index nonzero", sw_prod, 1);
        sw_prod = 0;
        publish();
        @(posedge clk);
        #1;
        ring_clr = 1'b1;
        @(posedge clk);
        #1;
        ring_clr = 1'b0;
        chk(cons_idx == '0, "R10", "cons after clear", int'(cons_idx), 0);
        enable = 1'b1;
        enq(5, 1, 1, 4'b1111);
        publish();
        drain();
        chk(int'(cons_idx) == 1, "R10", "restart from slot zero", int'(cons_idx), 1);

        chk(wraps >= 2, "R6", "ring wraps observed", wraps, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule